// File: doc/BRIEF.md
# Transport Packet PID Router

This block sits on a byte-wide MPEG-2 transport stream, one byte per clock, with a strobe marking the first byte of each 188-byte packet. It reads the four-byte header of every packet and compares the 13-bit packet identifier against eight programmable slots. Six of them are service slots: a packet that lands on one of these is tagged encrypted when its scrambling-control bits are nonzero, or always when the forced-encryption setting is on. The other two are entitlement-message slots: their packets leave on a separate message port instead of the main output.

Every byte leaves the block exactly four clocks after it entered. Each packet carries a tag (hit flag, slot number and encrypted flag) that is already valid with its first byte. A packet whose first byte is not the sync value 0x47 is discarded, and a one-cycle error pulse is raised. Slots and the forced-encryption setting are loaded through a small register write port.

Top module: `pid_router`

## Requirements
- R1: While reset is held and until the first packet emerges, `out_valid`, `ecm_valid` and `sync_err` are low.
- R2: A packet on an identifier that no enabled slot holds leaves on the main port unchanged, byte for byte, four clocks after input, with `out_sop` on its first byte, `out_hit`=0, `out_slot`=0 and `out_enc`=0.
- R3: The identifier is {byte1[4:0], byte2[7:0]}, with bytes counted from 0 at the sync byte. A write with `cfg_addr` 0..7 loads slot `cfg_addr` with identifier `cfg_wdata[12:0]` and enable `cfg_wdata[13]`. A slot whose enable is 0 never matches.
- R4: A packet matching a service slot (0..5) leaves on the main port with `out_hit`=1 and `out_slot` equal to that slot. `out_enc` is 1 exactly when scrambling control, byte3[7:6], is nonzero.
- R5: A write to `cfg_addr` 8 sets forced encryption to `cfg_wdata[0]`. While it is set, every service-slot packet has `out_enc`=1, and unmatched packets keep `out_enc`=0.
- R6: A packet matching slot 6 or 7 appears only on the message port (`ecm_valid`, `ecm_sop`, `ecm_data`), with `ecm_slot` = slot-6. `out_valid` stays low for all its bytes.
- R7: A packet whose first byte is not 0x47 is dropped from both ports. `sync_err` is high for exactly the one cycle after that byte is sampled.
- R8: When several enabled slots hold the same identifier, the lowest-numbered slot wins.
- R9: The tag outputs stay constant over all bytes of a packet.
- R10: Bytes with `in_valid` high that arrive outside a packet (after byte 187 and before the next start) are not forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte present |
| in_sop | input | 1 | Input byte is byte 0 of a packet |
| in_data | input | 8 | Input stream byte |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | 0..7 slot, 8 forced-encryption |
| cfg_wdata | input | 14 | {enable, identifier} or forced flag in bit 0 |
| out_valid | output | 1 | Main port byte valid |
| out_sop | output | 1 | Main port first byte |
| out_data | output | 8 | Main port byte |
| out_hit | output | 1 | Packet matched a slot |
| out_slot | output | 3 | Matching slot number |
| out_enc | output | 1 | Packet to be descrambled |
| ecm_valid | output | 1 | Message port byte valid |
| ecm_sop | output | 1 | Message port first byte |
| ecm_data | output | 8 | Message port byte |
| ecm_slot | output | 1 | Which message slot matched |
| sync_err | output | 1 | Bad sync byte pulse |

## Verification
A wrong byte counter shows at once as a packet that is cut short, runs long, or leaks idle bytes. The error appears within four clocks of the fault, as a valid strobe at the wrong place. A header field captured from the wrong byte, or a bad priority or enable decode, shows on the very first output byte of the packet as a wrong hit, slot or encrypted flag, or as a packet sent to the wrong port. The reference model compares every port on every clock, so such a fault is seen in the cycle where it first becomes visible.

// File: rtl/pidr_pkg.sv
package pidr_pkg;
  localparam int PIDR_PID_W  = 13;
  localparam int PIDR_SLOT_W = 3;
  localparam int PIDR_HDR    = 4;
  localparam logic [7:0] PIDR_SYNC = 8'h47;

  typedef struct packed {
    logic                   hit;
    logic                   ecm;
    logic                   enc;
    logic [PIDR_SLOT_W-1:0] slot;
  } pidr_tag_t;
endpackage

// File: rtl/pidr_slot_table.sv
module pidr_slot_table #(
  parameter int NSLOT  = 8,
  parameter int PID_W  = 13,
  parameter int ADDR_W = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic [ADDR_W-1:0]           cfg_addr,
  input  logic [PID_W:0]              cfg_wdata,
  output logic [NSLOT-1:0][PID_W-1:0] slot_pid,
  output logic [NSLOT-1:0]            slot_en,
  output logic                        force_enc
);
  logic [NSLOT-1:0][PID_W-1:0] pid_d;
  logic [NSLOT-1:0]            en_d;
  logic                        force_d;

  always_comb begin
    pid_d   = slot_pid;
    en_d    = slot_en;
    force_d = force_enc;
    if (cfg_we) begin
      for (int i = 0; i < NSLOT; i++) begin
        if (cfg_addr == ADDR_W'(i)) begin
          pid_d[i] = cfg_wdata[PID_W-1:0];
          en_d[i]  = cfg_wdata[PID_W];
        end
      end
      if (cfg_addr == ADDR_W'(NSLOT)) force_d = cfg_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_pid  <= '0;
      slot_en   <= '0;
      force_enc <= 1'b0;
    end else begin
      slot_pid  <= pid_d;
      slot_en   <= en_d;
      force_enc <= force_d;
    end
  end
endmodule

// File: rtl/pidr_match.sv
module pidr_match
  import pidr_pkg::*;
#(
  parameter int NSLOT = 8,
  parameter int NSVC  = 6,
  parameter int PID_W = 13
) (
  input  logic [PID_W-1:0]            pid,
  input  logic [1:0]                  scr,
  input  logic                        force_enc,
  input  logic [NSLOT-1:0][PID_W-1:0] slot_pid,
  input  logic [NSLOT-1:0]            slot_en,
  output pidr_tag_t                   tag
);
  logic [NSLOT-1:0] hit_vec;

  for (genvar g = 0; g < NSLOT; g++) begin : g_cmp
    assign hit_vec[g] = slot_en[g] && (slot_pid[g] == pid);
  end

  // lowest index overrides, so it is applied last
  always_comb begin
    tag = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        tag.hit  = 1'b1;
        tag.slot = PIDR_SLOT_W'(i);
        tag.ecm  = (i >= NSVC);
        tag.enc  = (i < NSVC) && (force_enc || (scr != 2'b00));
      end
    end
  end
endmodule

// File: rtl/pidr_hdr_parse.sv
module pidr_hdr_parse
  import pidr_pkg::*;
#(
  parameter int PKT_LEN = 188,
  parameter int PID_W   = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sop,
  input  logic [7:0]       in_data,
  input  pidr_tag_t        tag_in,
  output logic [PID_W-1:0] pid,
  output pidr_tag_t        tag_q,
  output logic             fwd_v,
  output logic             fwd_sop,
  output logic             sync_err
);
  localparam int CNT_W = $clog2(PKT_LEN);

  logic             act_q, act_d, drop_q, drop_d, serr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [4:0]       h1_q, h1_d;
  logic [7:0]       h2_q, h2_d;
  pidr_tag_t        tag_d;
  logic             start, sync_ok, body;

  assign start   = in_valid && in_sop;
  assign sync_ok = (in_data == PIDR_SYNC);
  assign body    = in_valid && !in_sop && act_q;
  assign pid     = {h1_q, h2_q};
  assign fwd_v   = start ? sync_ok : (body && !drop_q);
  assign fwd_sop = start && sync_ok;

  always_comb begin
    act_d  = act_q;
    cnt_d  = cnt_q;
    drop_d = drop_q;
    h1_d   = h1_q;
    h2_d   = h2_q;
    tag_d  = tag_q;
    serr_d = start && !sync_ok;
    if (start) begin
      act_d  = 1'b1;
      cnt_d  = CNT_W'(1);
      drop_d = !sync_ok;
    end else if (body) begin
      if (cnt_q == CNT_W'(PKT_LEN - 1)) act_d = 1'b0;
      else                              cnt_d = cnt_q + CNT_W'(1);
      if (cnt_q == CNT_W'(1)) h1_d = in_data[4:0];
      if (cnt_q == CNT_W'(2)) h2_d = in_data;
      if (cnt_q == CNT_W'(PIDR_HDR - 1) && !drop_q) tag_d = tag_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q    <= 1'b0;
      cnt_q    <= '0;
      drop_q   <= 1'b0;
      h1_q     <= '0;
      h2_q     <= '0;
      tag_q    <= '0;
      sync_err <= 1'b0;
    end else begin
      act_q    <= act_d;
      cnt_q    <= cnt_d;
      drop_q   <= drop_d;
      h1_q     <= h1_d;
      h2_q     <= h2_d;
      tag_q    <= tag_d;
      sync_err <= serr_d;
    end
  end

  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (cnt_q < CNT_W'(PKT_LEN)));
  p_serr_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |-> $past(in_valid && in_sop && in_data != PIDR_SYNC));
  p_enc_svc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tag_q.enc |-> (tag_q.hit && !tag_q.ecm));
endmodule

// File: rtl/pidr_delay.sv
module pidr_delay #(
  parameter int W     = 10,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [DEPTH-1:0][W-1:0] stg;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stg
    logic [W-1:0] nxt;
    if (g == 0) begin : g_first
      assign nxt = din;
    end else begin : g_next
      assign nxt = stg[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[g] <= '0;
      else        stg[g] <= nxt;
    end
  end

  assign dout = stg[DEPTH-1];
endmodule

// File: rtl/pid_router.sv
module pid_router
  import pidr_pkg::*;
#(
  parameter int PKT_LEN = 188,
  parameter int NSVC    = 6,
  parameter int NECM    = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        in_sop,
  input  logic [7:0]  in_data,
  input  logic        cfg_we,
  input  logic [3:0]  cfg_addr,
  input  logic [13:0] cfg_wdata,
  output logic        out_valid,
  output logic        out_sop,
  output logic [7:0]  out_data,
  output logic        out_hit,
  output logic [2:0]  out_slot,
  output logic        out_enc,
  output logic        ecm_valid,
  output logic        ecm_sop,
  output logic [7:0]  ecm_data,
  output logic [0:0]  ecm_slot,
  output logic        sync_err
);
  localparam int NSLOT  = NSVC + NECM;
  localparam int ADDR_W = $clog2(NSLOT + 1);
  localparam int ECM_W  = (NECM > 1) ? $clog2(NECM) : 1;
  localparam int DW     = 10;

  logic [NSLOT-1:0][PIDR_PID_W-1:0] slot_pid;
  logic [NSLOT-1:0]                 slot_en;
  logic                             force_enc;
  logic [PIDR_PID_W-1:0]            pid;
  pidr_tag_t                        tag_new, tag_q;
  logic                             fwd_v, fwd_sop;
  logic [DW-1:0]                    d_in, d_out;
  logic                             dv, dsop;
  logic [7:0]                       dbyte;

  pidr_slot_table #(.NSLOT(NSLOT), .PID_W(PIDR_PID_W), .ADDR_W(ADDR_W)) u_table (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr[ADDR_W-1:0]),
    .cfg_wdata(cfg_wdata), .slot_pid(slot_pid), .slot_en(slot_en), .force_enc(force_enc));

  pidr_match #(.NSLOT(NSLOT), .NSVC(NSVC), .PID_W(PIDR_PID_W)) u_match (
    .pid(pid), .scr(in_data[7:6]), .force_enc(force_enc),
    .slot_pid(slot_pid), .slot_en(slot_en), .tag(tag_new));

  pidr_hdr_parse #(.PKT_LEN(PKT_LEN), .PID_W(PIDR_PID_W)) u_parse (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_data(in_data),
    .tag_in(tag_new), .pid(pid), .tag_q(tag_q), .fwd_v(fwd_v), .fwd_sop(fwd_sop),
    .sync_err(sync_err));

  assign d_in = {fwd_v, fwd_sop, in_data};

  pidr_delay #(.W(DW), .DEPTH(PIDR_HDR)) u_delay (
    .clk(clk), .rst_n(rst_n), .din(d_in), .dout(d_out));

  assign {dv, dsop, dbyte} = d_out;

  assign out_valid = dv && !tag_q.ecm;
  assign out_sop   = dsop && !tag_q.ecm;
  assign out_data  = dbyte;
  assign out_hit   = tag_q.hit;
  assign out_slot  = tag_q.slot;
  assign out_enc   = tag_q.enc;
  assign ecm_valid = dv && tag_q.ecm;
  assign ecm_sop   = dsop && tag_q.ecm;
  assign ecm_data  = dbyte;
  assign ecm_slot  = ECM_W'(tag_q.slot - PIDR_SLOT_W'(NSVC));

  p_port_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && ecm_valid));
  p_sop_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_sop |-> ($past(in_sop, 4) && $past(in_data, 4) == PIDR_SYNC));
  p_tag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_sop && $past(out_valid)) |-> $stable({out_hit, out_slot, out_enc}));
endmodule

// File: tb/test_pid_router.sv
`timescale 1ns/1ps
module test_pid_router;
  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_sop, cfg_we;
  logic [7:0] in_data;
  logic [3:0] cfg_addr;
  logic [13:0] cfg_wdata;
  logic out_valid, out_sop, out_hit, out_enc, ecm_valid, ecm_sop, sync_err;
  logic [7:0] out_data, ecm_data;
  logic [2:0] out_slot;
  logic [0:0] ecm_slot;

  always #2 clk = ~clk;

  pid_router i_pid_router (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_data(in_data),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .out_valid(out_valid), .out_sop(out_sop), .out_data(out_data), .out_hit(out_hit),
    .out_slot(out_slot), .out_enc(out_enc), .ecm_valid(ecm_valid), .ecm_sop(ecm_sop),
    .ecm_data(ecm_data), .ecm_slot(ecm_slot), .sync_err(sync_err));

  typedef struct {
    bit ov, ev, sop;
    bit [7:0] data;
    bit hit, enc, eslot;
    bit [2:0] slot;
    string req, treq;
  } exp_t;

  exp_t q[$];
  int nchk = 0, nerr = 0;
  bit prev_bad = 0;
  bit [12:0] m_pid [8];
  bit m_en [8];
  bit m_force = 0;

  task automatic chk(string req, string what, int act, int expv);
    nchk++;
    if (act != expv) begin
      nerr++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic exp_t idle(string req);
    exp_t e;
    e.ov = 0; e.ev = 0; e.sop = 0; e.data = 0; e.hit = 0; e.enc = 0;
    e.eslot = 0; e.slot = 0; e.req = req; e.treq = req;
    return e;
  endfunction

  task automatic compare(exp_t e);
    chk(e.req, "out_valid", int'(out_valid), int'(e.ov));
    chk(e.req, "ecm_valid", int'(ecm_valid), int'(e.ev));
    if (e.ov) begin
      chk(e.req, "out_sop", int'(out_sop), int'(e.sop));
      chk(e.req, "out_data", int'(out_data), int'(e.data));
      chk(e.treq, "out_hit", int'(out_hit), int'(e.hit));
      chk(e.treq, "out_slot", int'(out_slot), int'(e.slot));
      chk(e.treq, "out_enc", int'(out_enc), int'(e.enc));
    end
    if (e.ev) begin
      chk(e.req, "ecm_sop", int'(ecm_sop), int'(e.sop));
      chk(e.req, "ecm_data", int'(ecm_data), int'(e.data));
      chk(e.treq, "ecm_slot", int'(ecm_slot), int'(e.eslot));
    end
  endtask

  task automatic step(bit v, bit s, bit [7:0] d, bit we, bit [3:0] a, bit [13:0] w, exp_t e);
    @(negedge clk);
    compare(q.pop_front());
    chk("R7", "sync_err", int'(sync_err), int'(prev_bad));
    in_valid = v; in_sop = s; in_data = d;
    cfg_we = we; cfg_addr = a; cfg_wdata = w;
    prev_bad = v && s && (d != 8'h47);
    q.push_back(e);
  endtask

  task automatic wr(bit [3:0] a, bit [13:0] w);
    step(0, 0, 8'h00, 1, a, w, idle("R3"));
    if (a < 8) begin m_pid[a] = w[12:0]; m_en[a] = w[13]; end
    else if (a == 8) m_force = w[0];
  endtask

  task automatic gap(int n, bit junk);
    for (int i = 0; i < n; i++) step(junk, 0, 8'hA5, 0, 0, 0, idle("R10"));
  endtask

  task automatic send_pkt(bit [12:0] pid, bit [1:0] sc, bit good, string req);
    bit hit = 0, ecm = 0, enc = 0;
    bit [2:0] slot = 0;
    for (int i = 7; i >= 0; i--) begin
      if (m_en[i] && m_pid[i] == pid) begin
        hit = 1; slot = 3'(i); ecm = (i >= 6);
        enc = (i < 6) && (m_force || sc != 2'b00);
      end
    end
    for (int i = 0; i < 188; i++) begin
      bit [7:0] b;
      exp_t e;
      case (i)
        0: b = good ? 8'h47 : 8'h46;
        1: b = {3'b101, pid[12:8]};
        2: b = pid[7:0];
        3: b = {sc, 6'h15};
        default: b = 8'(i * 7 + int'(pid));
      endcase
      e = idle(req);
      if (good) begin
        e.ov = !ecm; e.ev = ecm; e.sop = (i == 0); e.data = b;
        e.hit = hit; e.slot = slot; e.enc = enc; e.eslot = slot[0];
        e.treq = (i == 0) ? req : "R9";
      end
      step(1, i == 0, b, 0, 0, 0, e);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 8; i++) begin m_pid[i] = 0; m_en[i] = 0; end
    rst_n = 0; in_valid = 0; in_sop = 0; in_data = 0;
    cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    repeat (3) @(negedge clk);
    chk("R1", "out_valid in reset", int'(out_valid), 0);
    chk("R1", "ecm_valid in reset", int'(ecm_valid), 0);
    chk("R1", "sync_err in reset", int'(sync_err), 0);
    rst_n = 1;
    for (int i = 0; i < 4; i++) q.push_back(idle("R1"));

    gap(3, 0);
    send_pkt(13'h0100, 2'b00, 1, "R2");
    gap(2, 1);
    wr(0, {1'b1, 13'h01FF});
    wr(1, {1'b1, 13'h00AB});
    wr(2, {1'b1, 13'h00AB});
    wr(3, {1'b0, 13'h0300});
    wr(5, {1'b1, 13'h1234});
    wr(6, {1'b1, 13'h1FFE});
    wr(7, {1'b1, 13'h0020});
    gap(2, 0);
    send_pkt(13'h01FF, 2'b00, 1, "R4");
    send_pkt(13'h01FF, 2'b10, 1, "R4");
    gap(5, 1);
    send_pkt(13'h00AB, 2'b11, 1, "R8");
    send_pkt(13'h1234, 2'b01, 1, "R3");
    send_pkt(13'h0300, 2'b10, 1, "R3");
    send_pkt(13'h1FFE, 2'b00, 1, "R6");
    send_pkt(13'h0020, 2'b10, 1, "R6");
    send_pkt(13'h01FF, 2'b01, 0, "R7");
    send_pkt(13'h0100, 2'b00, 1, "R2");
    wr(8, 14'h0001);
    send_pkt(13'h01FF, 2'b00, 1, "R5");
    send_pkt(13'h0100, 2'b00, 1, "R5");
    send_pkt(13'h1FFE, 2'b00, 1, "R5");
    wr(8, 14'h0000);
    send_pkt(13'h00AB, 2'b00, 1, "R5");
    gap(8, 1);
    finish_run();
  end
endmodule